// File: doc/BRIEF.md
# LCD Common-Row Scan Driver Logic

This block is the digital core of a dot-matrix LCD common (row) driver. A long scan register carries one or more "select" tokens across the rows. The token advances one stage each time the LOAD strobe goes from high to low. Shifting runs toward higher or lower row numbers, as the direction input chooses. Cascade end pins pass tokens between chained devices, so one frame can span more rows than a single device has. This allows duties from 1/160 to 1/480.

A split control makes the register act as two independent half-length registers, each with its own pair of cascade end pins. For every row the block produces a registered 2-bit drive-level code. The code depends on the row's select bit, the frame-alternation input and the display-off input. Analog level shifting and high-voltage output stages lie outside the block; downstream logic uses the codes to pick the row voltage.

The block runs on a free-running clock. LOAD is sampled and its falling edge is detected synchronously. On the clock edge that sees the fall, the scan register, the cascade outputs and the level codes all update together.

Top module: `lcd_row_scan`

## Requirements
- R1: A shift event happens on a rising `clk` edge where `load` is 0 and `load` was 1 at the previous edge. On every other edge after reset, `level` and `casc_out` hold their values, even while `load` stays high.
- R2: With `dir`=0 and `split`=0, stage 0 takes `casc_in[0]` and stage i takes stage i-1, so tokens move toward higher row numbers.
- R3: With `dir`=1 and `split`=0, stage ROWS-1 takes `casc_in[3]` and stage i takes stage i+1, so tokens move toward lower row numbers.
- R4: With `split`=1 the lower half (rows 0..ROWS/2-1) and the upper half (rows ROWS/2..ROWS-1) shift independently. A token never crosses between the halves. For `dir`=0 the halves load from `casc_in[0]` and `casc_in[2]`. For `dir`=1 they load from `casc_in[1]` and `casc_in[3]`.
- R5: At each shift event, every enabled cascade pin outputs the stage being shifted out of its end. Pin 0 outputs row 0, pin 1 row ROWS/2-1, pin 2 row ROWS/2 and pin 3 row ROWS-1. The value is registered and held until the next shift. Pins that are not enabled output 0.
- R6: `casc_oe` is combinational from the mode inputs: 4'b1000 for `dir`=0,`split`=0; 4'b1010 for `dir`=0,`split`=1; 4'b0001 for `dir`=1,`split`=0; 4'b0101 for `dir`=1,`split`=1.
- R7: Cascade inputs that the current mode does not use have no effect on the scan register.
- R8: Row i's code sits at `level[2i+1:2i]`. The encoding is V0=2'b00, V1=2'b01, V4=2'b10 and V5=2'b11. A selected row gives V0 when `df`=1 and V5 when `df`=0. An unselected row gives V4 when `df`=1 and V1 when `df`=0.
- R9: When `disp_off` is 1 at a shift event, every row code becomes V5, whatever the register holds.
- R10: `df` and `disp_off` are sampled only at shift events. Changing them between shifts leaves `level` unchanged.
- R11: A synchronous active-high `rst` clears every stage to unselected, clears `casc_out` to 0 and sets all row codes to V5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Shift strobe; its falling edge advances the register |
| dir | input | 1 | 0: toward higher rows, 1: toward lower rows |
| split | input | 1 | 1: two independent half-length registers |
| df | input | 1 | Frame-alternation polarity |
| disp_off | input | 1 | Force all rows to V5 |
| casc_in | input | 4 | Cascade token inputs for the four end pins |
| casc_out | output | 4 | Registered cascade token outputs |
| casc_oe | output | 4 | Output enable for each cascade end pin |
| level | output | 2*ROWS | Per-row 2-bit drive-level codes |

## Verification
The bench uses an eight-row instance and walks a single token through the whole register in each direction. This separates the two neighbour selections and shows the end stage leaving through the correct cascade pin one shift later. Two tokens entered a few shifts apart check that stages copy their neighbours without merging or losing tokens. Split-mode patterns then load both halves at once and show that a token leaving one half appears only on that half's pin and never in the other half. Along the way, frame polarity and display-off change, and unused cascade pins carry ones, so the encoding, the forced level and the ignored inputs are each checked separately.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    DRV_V0 = 2'b00,
    DRV_V1 = 2'b01,
    DRV_V4 = 2'b10,
    DRV_V5 = 2'b11
  } drv_code_e;

  localparam int CODE_W  = 2;
  localparam int NUM_END = 4;
  // cascade end pin positions
  localparam int END_LO   = 0;
  localparam int END_MIDL = 1;
  localparam int END_MIDH = 2;
  localparam int END_HI   = 3;
endpackage

// File: rtl/load_fall_det.sv
module load_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic fall_o
);
  logic load_q;

  always_ff @(posedge clk) begin
    if (rst) load_q <= 1'b0;
    else     load_q <= load_i;
  end

  assign fall_o = load_q & ~load_i;
endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 240
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_i,
  input  logic                dir_i,
  input  logic                split_i,
  input  logic [NUM_END-1:0]  end_in_i,
  output logic [ROWS-1:0]     nxt_o,
  output logic [NUM_END-1:0]  end_out_o,
  output logic [NUM_END-1:0]  end_oe_o
);
  localparam int HALF = ROWS / 2;

  logic [ROWS-1:0]    stage_q;
  logic [ROWS-1:0]    up_src;
  logic [ROWS-1:0]    dn_src;
  logic [NUM_END-1:0] out_nxt;
  logic [NUM_END-1:0] out_q;

  // neighbour selection per stage; half boundaries take the mid pins in split mode
  for (genvar i = 0; i < ROWS; i++) begin : g_stage
    if (i == 0) begin : g_up_lo
      assign up_src[i] = end_in_i[END_LO];
    end else if (i == HALF) begin : g_up_mid
      assign up_src[i] = split_i ? end_in_i[END_MIDH] : stage_q[i-1];
    end else begin : g_up_in
      assign up_src[i] = stage_q[i-1];
    end

    if (i == ROWS - 1) begin : g_dn_hi
      assign dn_src[i] = end_in_i[END_HI];
    end else if (i == HALF - 1) begin : g_dn_mid
      assign dn_src[i] = split_i ? end_in_i[END_MIDL] : stage_q[i+1];
    end else begin : g_dn_in
      assign dn_src[i] = stage_q[i+1];
    end

    assign nxt_o[i] = dir_i ? dn_src[i] : up_src[i];
  end

  always_comb begin
    unique case ({dir_i, split_i})
      2'b00:   end_oe_o = 4'b1000;
      2'b01:   end_oe_o = 4'b1010;
      2'b10:   end_oe_o = 4'b0001;
      default: end_oe_o = 4'b0101;
    endcase
  end

  assign out_nxt[END_LO]   = stage_q[0];
  assign out_nxt[END_MIDL] = stage_q[HALF-1];
  assign out_nxt[END_MIDH] = stage_q[HALF];
  assign out_nxt[END_HI]   = stage_q[ROWS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      out_q   <= '0;
    end else if (shift_i) begin
      stage_q <= nxt_o;
      out_q   <= out_nxt & end_oe_o;
    end
  end

  assign end_out_o = out_q;
endmodule

// File: rtl/level_encoder.sv
module level_encoder
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 240
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_i,
  input  logic [ROWS-1:0]        sel_i,
  input  logic                   df_i,
  input  logic                   off_i,
  output logic [CODE_W*ROWS-1:0] level_o
);
  localparam int LW = CODE_W * ROWS;

  logic [LW-1:0] code_nxt;
  logic [LW-1:0] code_q;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    drv_code_e c;
    always_comb begin
      if (off_i)          c = DRV_V5;
      else if (sel_i[i])  c = df_i ? DRV_V0 : DRV_V5;
      else                c = df_i ? DRV_V4 : DRV_V1;
    end
    assign code_nxt[CODE_W*i +: CODE_W] = c;
  end

  always_ff @(posedge clk) begin
    if (rst)          code_q <= '1;
    else if (shift_i) code_q <= code_nxt;
  end

  assign level_o = code_q;
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 240
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   dir,
  input  logic                   split,
  input  logic                   df,
  input  logic                   disp_off,
  input  logic [3:0]             casc_in,
  output logic [3:0]             casc_out,
  output logic [3:0]             casc_oe,
  output logic [2*ROWS-1:0]      level
);
  logic            shift;
  logic [ROWS-1:0] sel_nxt;

  load_fall_det u_fall (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .fall_o (shift)
  );

  scan_chain #(.ROWS(ROWS)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .shift_i   (shift),
    .dir_i     (dir),
    .split_i   (split),
    .end_in_i  (casc_in),
    .nxt_o     (sel_nxt),
    .end_out_o (casc_out),
    .end_oe_o  (casc_oe)
  );

  level_encoder #(.ROWS(ROWS)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift),
    .sel_i   (sel_nxt),
    .df_i    (df),
    .off_i   (disp_off),
    .level_o (level)
  );
endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
  parameter int ROWS = 240
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              split,
  input logic              disp_off,
  input logic [3:0]        casc_out,
  input logic [3:0]        casc_oe,
  input logic [2*ROWS-1:0] level
);
  logic load_d;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) load_d <= 1'b0;
    else     load_d <= load;
  end
  assign fall = load_d & ~load;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (casc_out == 4'b0 && level == '1)); // R11
  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (rst) !fall |=> ($stable(level) && $stable(casc_out))); // R1
  AST_OFF_ALL_V5: assert property (@(posedge clk) disable iff (rst) (fall && disp_off) |=> (level == '1)); // R9
  AST_OE_COUNT: assert property (@(posedge clk) disable iff (rst) $countones(casc_oe) == (split ? 2 : 1)); // R6
  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (rst) fall |=> ((casc_out & ~$past(casc_oe)) == 4'b0)); // R5
endmodule

bind lcd_row_scan lcd_row_scan_chk #(.ROWS(ROWS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .split    (split),
  .disp_off (disp_off),
  .casc_out (casc_out),
  .casc_oe  (casc_oe),
  .level    (level)
);

// File: tb/tb_lcd_row_scan.sv
module tb_lcd_row_scan;
  localparam int R  = 8;
  localparam int LW = 2 * R;
  localparam int NV = 33;

  // {dir, split, df, off, casc_in[3:0], expected stages[7:0], expected casc_out[3:0]}
  localparam logic [19:0] VEC [0:NV-1] = '{
    20'b0_0_1_0_0001_00000001_0000,
    20'b0_0_0_0_1110_00000010_0000,
    20'b0_0_1_0_0000_00000100_0000,
    20'b0_0_0_0_0000_00001000_0000,
    20'b0_0_1_1_0000_00010000_0000,
    20'b0_0_0_0_0000_00100000_0000,
    20'b0_0_1_0_0000_01000000_0000,
    20'b0_0_0_0_0000_10000000_0000,
    20'b0_0_1_0_0000_00000000_1000,
    20'b0_0_0_0_0000_00000000_0000,
    20'b1_0_1_0_1000_10000000_0000,
    20'b1_0_0_0_0111_01000000_0000,
    20'b1_0_1_0_1000_10100000_0000,
    20'b1_0_0_0_0000_01010000_0000,
    20'b1_0_1_0_0000_00101000_0000,
    20'b1_0_0_0_0000_00010100_0000,
    20'b1_0_1_0_0000_00001010_0000,
    20'b1_0_0_0_0000_00000101_0000,
    20'b1_0_1_0_0000_00000010_0001,
    20'b1_0_0_0_0000_00000001_0000,
    20'b1_0_1_0_0000_00000000_0001,
    20'b0_1_0_0_0101_00010001_0000,
    20'b0_1_1_0_1010_00100010_0000,
    20'b0_1_0_0_0000_01000100_0000,
    20'b0_1_1_0_0000_10001000_0000,
    20'b0_1_0_0_0000_00000000_1010,
    20'b0_1_1_0_0001_00000001_0000,
    20'b1_1_0_0_0010_00001000_0001,
    20'b1_1_1_0_1000_10000100_0000,
    20'b1_1_0_1_0101_01000010_0000,
    20'b1_1_1_0_0000_00100001_0000,
    20'b1_1_0_0_0000_00010000_0001,
    20'b1_1_1_0_0000_00000000_0100
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic dir = 1'b0;
  logic split = 1'b0;
  logic df = 1'b0;
  logic disp_off = 1'b0;
  logic [3:0] casc_in = 4'b0;
  logic [3:0] casc_out;
  logic [3:0] casc_oe;
  logic [LW-1:0] level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_row_scan #(.ROWS(R)) dut (
    .clk(clk), .rst(rst), .load(load), .dir(dir), .split(split), .df(df),
    .disp_off(disp_off), .casc_in(casc_in), .casc_out(casc_out),
    .casc_oe(casc_oe), .level(level)
  );

  // R8/R9 encoding: V0=00 V1=01 V4=10 V5=11
  function automatic logic [LW-1:0] exp_level(input logic [R-1:0] q, input logic f, input logic o);
    logic [LW-1:0] v;
    for (int i = 0; i < R; i++) begin
      if (o)         v[2*i +: 2] = 2'b11;
      else if (q[i]) v[2*i +: 2] = f ? 2'b00 : 2'b11;
      else           v[2*i +: 2] = f ? 2'b10 : 2'b01;
    end
    return v;
  endfunction

  function automatic logic [3:0] exp_oe(input logic d, input logic s);
    case ({d, s})
      2'b00:   return 4'b1000;
      2'b01:   return 4'b1010;
      2'b10:   return 4'b0001;
      default: return 4'b0101;
    endcase
  endfunction

  task automatic check(input string req, input logic [LW-1:0] got, input logic [LW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input logic d, input logic s, input logic f, input logic o, input logic [3:0] ci);
    @(negedge clk);
    dir = d; split = s; df = f; disp_off = o; casc_in = ci; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] snap;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset level", level, '1);
    check("R11 reset casc_out", {12'b0, casc_out}, 16'b0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      logic [19:0] v;
      v = VEC[k];
      pulse(v[19], v[18], v[17], v[16], v[15:12]);
      check($sformatf("R2/R3/R4/R7/R8/R9 step %0d level", k), level,
            exp_level(v[11:4], v[17], v[16]));
      check($sformatf("R5 step %0d casc_out", k), {12'b0, casc_out}, {12'b0, v[3:0]});
      check($sformatf("R6 step %0d casc_oe", k), {12'b0, casc_oe}, {12'b0, exp_oe(v[19], v[18])});
    end

    // R10: df and disp_off ignored between shifts
    snap = level;
    df = 1'b0; disp_off = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 df/off without shift", level, snap);

    // R1: load held high never shifts
    load = 1'b1; casc_in = 4'b1111;
    repeat (5) @(negedge clk);
    check("R1 load held high", level, snap);
    load = 1'b0; casc_in = 4'b0;
    @(negedge clk);
    check("R9 fall with display off", level, '1);

    // token entry, then R11 mid-run reset
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 4'b0001);
    check("R2 token entry", level, exp_level(8'b00000001, 1'b1, 1'b0));
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 mid-run reset level", level, '1);
    check("R11 mid-run reset casc_out", {12'b0, casc_out}, 16'b0);
    rst = 1'b0;
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 4'b0000);
    check("R11 stages cleared", level, exp_level(8'b00000000, 1'b1, 1'b0));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule